// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block receives SMBus Host Notify messages addressed to the fixed host address 0001000b. It samples the raw SCL and SDA wires, frames bytes and pulls SDA low to acknowledge each accepted byte. A notify frame has four bytes, each followed by an ACK clock: the host address with a write bit, the device address of the notifying master, then the low data byte and the high data byte. A stop condition closes the frame.

When a complete frame closes with a stop, the block copies the device address and the 16-bit data word into three holding registers. It then sets a pending status bit. The interrupt request is the status bit gated by an enable input. While the status bit is set, the block refuses any new notify frame by leaving the address byte unacknowledged, so the held values stay intact until software services them. Software clears the status with a one-cycle write-one-to-clear pulse, and the block then accepts the next notification.

Top module: `smb_notify_rx`

## Requirements
- R1: After reset, the status bit, the interrupt request and the SDA pull-down are 0, and the three holding registers read 0.
- R2: When the status bit is clear, a first byte whose upper seven bits are 0001000 and whose least significant (eighth) bit is 0 is acknowledged: SDA is held low during the ninth SCL clock of that byte.
- R3: A first byte with any other address, or with its eighth bit at 1, is not acknowledged. The rest of that frame is ignored (no ACK and no register change) up to the next start or stop.
- R4: In an accepted frame, the upper seven bits of the second byte (first-received bit first) are stored as the device address. Its trailing bit is discarded.
- R5: In an accepted frame, the second, third and fourth bytes are each acknowledged. The third byte is stored as the low data byte and the fourth as the high data byte.
- R6: The holding registers change and the status bit sets only when a stop follows the ACK of the fourth byte. A frame cut short by a stop leaves the registers and status unchanged.
- R7: While the status bit is set, the host address byte is not acknowledged and the holding registers keep their values.
- R8: A one-cycle pulse on the clear input clears the status bit on the next clock, after which a new notification is accepted again.
- R9: The interrupt request is high exactly when the status bit and the interrupt enable are both high.
- R10: A repeated start in the middle of a frame discards the partial frame and starts decoding a new frame from its address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock wire as seen at the pad |
| sda_i | input | 1 | SMBus data wire as seen at the pad |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain ACK) |
| intr_en_i | input | 1 | Interrupt enable |
| sts_clr_i | input | 1 | Write-one-to-clear pulse for the status bit |
| notify_sts_o | output | 1 | Pending notification status |
| notify_irq_o | output | 1 | Interrupt request |
| dev_addr_o | output | 7 | Held device address of the notifying master |
| data_lo_o | output | 8 | Held low data byte |
| data_hi_o | output | 8 | Held high data byte |

## Verification
The bus is driven at 20 system clocks per bit. The block sees each wire edge three clocks late: two synchroniser flops plus one edge register. Its ACK pull-down therefore starts about three clocks after the SCL fall that ends the eighth bit. The bench samples the resolved SDA line five clocks into the high phase of the ninth clock, well clear of both edges. The holding registers and status update one clock after the stop is detected, about four clocks after SDA rises, and the bench checks them ten clocks after the stop. A clear pulse takes effect on the next clock, and the status is read two clocks later.

// File: rtl/smbn_pkg.sv
package smbn_pkg;

  // Bytes in one notify frame: host address, device address, data low, data high.
  localparam int unsigned FRAME_BYTES = 4;
  localparam int unsigned IDX_W       = $clog2(FRAME_BYTES);
  localparam int unsigned BYTE_BITS   = 8;
  localparam int unsigned CNT_W       = $clog2(BYTE_BITS + 1);

  typedef enum logic [2:0] {
    FR_IDLE,   // bus free or no frame of ours
    FR_DATA,   // shifting in a byte
    FR_ACK,    // driving the acknowledge clock
    FR_TAIL,   // all bytes acknowledged, waiting for stop
    FR_SKIP    // frame not for us, ignore until start or stop
  } fr_state_e;

endpackage

// File: rtl/smbn_line_sync.sv
module smbn_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ff_q, scl_ff_n;
  logic [STAGES-1:0] sda_ff_q, sda_ff_n;
  logic              scl_d_q, sda_d_q;
  logic              scl_s, sda_s;

  assign scl_s = scl_ff_q[STAGES-1];
  assign sda_s = sda_ff_q[STAGES-1];

  always_comb begin
    scl_ff_n = {scl_ff_q[STAGES-2:0], scl_i};
    sda_ff_n = {sda_ff_q[STAGES-2:0], sda_i};
  end

  // Idle bus level is high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff_q <= '1;
      sda_ff_q <= '1;
      scl_d_q  <= 1'b1;
      sda_d_q  <= 1'b1;
    end else begin
      scl_ff_q <= scl_ff_n;
      sda_ff_q <= sda_ff_n;
      scl_d_q  <= scl_s;
      sda_d_q  <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_d_q;
  assign scl_fall_o = ~scl_s & scl_d_q;
  assign start_o    = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_o     = scl_s & scl_d_q & ~sda_d_q & sda_s;

endmodule

// File: rtl/smbn_frame.sv
module smbn_frame
  import smbn_pkg::*;
#(
  parameter logic [6:0] HOST_ADDR = 7'b0001000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       pending_i,
  output logic       pull_o,
  output logic       commit_o,
  output logic [6:0] stg_dev_o,
  output logic [7:0] stg_lo_o,
  output logic [7:0] stg_hi_o
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  fr_state_e        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [7:0]       sh_q, sh_n;
  logic             pull_q, pull_n;
  logic [6:0]       dev_q, dev_n;
  logic [7:0]       lo_q, lo_n;
  logic [7:0]       hi_q, hi_n;
  logic             addr_hit;

  assign addr_hit = (sh_q == {HOST_ADDR, 1'b0});

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    pull_n = pull_q;
    dev_n  = dev_q;
    lo_n   = lo_q;
    hi_n   = hi_q;
    if (start_i) begin
      st_n   = FR_DATA;
      cnt_n  = '0;
      idx_n  = '0;
      pull_n = 1'b0;
    end else if (stop_i) begin
      st_n   = FR_IDLE;
      pull_n = 1'b0;
    end else begin
      unique case (st_q)
        FR_DATA: begin
          if (scl_rise_i && (cnt_q != FULL_CNT)) begin
            sh_n  = {sh_q[6:0], sda_s_i};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall_i && (cnt_q == FULL_CNT)) begin
            if (idx_q == '0) begin
              if (addr_hit && !pending_i) begin
                pull_n = 1'b1;
                st_n   = FR_ACK;
              end else begin
                st_n   = FR_SKIP;
              end
            end else begin
              pull_n = 1'b1;
              st_n   = FR_ACK;
              if (idx_q == IDX_W'(1)) dev_n = sh_q[7:1];
              if (idx_q == IDX_W'(2)) lo_n  = sh_q;
              if (idx_q == LAST_IDX)  hi_n  = sh_q;
            end
          end
        end
        FR_ACK: begin
          if (scl_fall_i) begin
            pull_n = 1'b0;
            cnt_n  = '0;
            if (idx_q == LAST_IDX) begin
              st_n = FR_TAIL;
            end else begin
              idx_n = idx_q + 1'b1;
              st_n  = FR_DATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pull_q <= 1'b0;
      dev_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      pull_q <= pull_n;
      dev_q  <= dev_n;
      lo_q   <= lo_n;
      hi_q   <= hi_n;
    end
  end

  assign pull_o    = pull_q;
  assign commit_o  = stop_i && !start_i && (st_q == FR_TAIL);
  assign stg_dev_o = dev_q;
  assign stg_lo_o  = lo_q;
  assign stg_hi_o  = hi_q;

endmodule

// File: rtl/smbn_hold_regs.sv
module smbn_hold_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit_i,
  input  logic       clr_i,
  input  logic       intr_en_i,
  input  logic [6:0] stg_dev_i,
  input  logic [7:0] stg_lo_i,
  input  logic [7:0] stg_hi_i,
  output logic       sts_o,
  output logic       irq_o,
  output logic [6:0] dev_o,
  output logic [7:0] lo_o,
  output logic [7:0] hi_o
);

  logic       sts_q, sts_n;
  logic [6:0] dev_q, dev_n;
  logic [7:0] lo_q, lo_n;
  logic [7:0] hi_q, hi_n;
  logic       load_en;

  // A frame is only accepted while status is clear, so a commit never
  // meets a pending notification; set still wins over clear.
  assign load_en = commit_i && !sts_q;

  always_comb begin
    dev_n = dev_q;
    lo_n  = lo_q;
    hi_n  = hi_q;
    sts_n = sts_q;
    if (clr_i)   sts_n = 1'b0;
    if (load_en) begin
      dev_n = stg_dev_i;
      lo_n  = stg_lo_i;
      hi_n  = stg_hi_i;
      sts_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      dev_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      sts_q <= sts_n;
      dev_q <= dev_n;
      lo_q  <= lo_n;
      hi_q  <= hi_n;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q & intr_en_i;
  assign dev_o = dev_q;
  assign lo_o  = lo_q;
  assign hi_o  = hi_q;

endmodule

// File: rtl/smb_notify_rx.sv
module smb_notify_rx #(
  parameter logic [6:0]  HOST_ADDR   = 7'b0001000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       intr_en_i,
  input  logic       sts_clr_i,
  output logic       notify_sts_o,
  output logic       notify_irq_o,
  output logic [6:0] dev_addr_o,
  output logic [7:0] data_lo_o,
  output logic [7:0] data_hi_o
);

  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       commit;
  logic [6:0] stg_dev;
  logic [7:0] stg_lo, stg_hi;

  smbn_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  smbn_frame #(
    .HOST_ADDR (HOST_ADDR)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .pending_i  (notify_sts_o),
    .pull_o     (sda_pull_o),
    .commit_o   (commit),
    .stg_dev_o  (stg_dev),
    .stg_lo_o   (stg_lo),
    .stg_hi_o   (stg_hi)
  );

  smbn_hold_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .clr_i     (sts_clr_i),
    .intr_en_i (intr_en_i),
    .stg_dev_i (stg_dev),
    .stg_lo_i  (stg_lo),
    .stg_hi_i  (stg_hi),
    .sts_o     (notify_sts_o),
    .irq_o     (notify_irq_o),
    .dev_o     (dev_addr_o),
    .lo_o      (data_lo_o),
    .hi_o      (data_hi_o)
  );

endmodule

// File: rtl/smbn_notify_chk.sv
module smbn_notify_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sts,
  input logic       irq,
  input logic       pull,
  input logic       clr,
  input logic       commit,
  input logic       stop_det,
  input logic [6:0] dev,
  input logic [7:0] lo,
  input logic [7:0] hi
);

  assert_irq_needs_sts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts);

  assert_sts_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts) |-> $past(stop_det));

  assert_hold_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && $past(sts)) |-> ($stable(dev) && $stable(lo) && $stable(hi)));

  assert_no_ack_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sts |-> !pull);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !commit) |=> !sts);

  assert_regs_only_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> ($stable(dev) && $stable(lo) && $stable(hi)));

endmodule

bind smb_notify_rx smbn_notify_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sts      (notify_sts_o),
  .irq      (notify_irq_o),
  .pull     (sda_pull_o),
  .clr      (sts_clr_i),
  .commit   (commit),
  .stop_det (stop_det),
  .dev      (dev_addr_o),
  .lo       (data_lo_o),
  .hi       (data_hi_o)
);

// File: tb/test_smb_notify_rx.sv
module test_smb_notify_rx;

  localparam logic [6:0] HOST = 7'b0001000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       intr_en = 1'b0;
  logic       sts_clr = 1'b0;
  logic       sda_pull;
  logic       sts, irq;
  logic [6:0] dev;
  logic [7:0] lo, hi;
  logic       sda_line;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  bit       e_sts = 1'b0;
  bit [6:0] e_dev = '0;
  bit [7:0] e_lo  = '0;
  bit [7:0] e_hi  = '0;

  assign sda_line = sda_m & ~sda_pull;

  always #5ns clk = ~clk;

  smb_notify_rx i_smb_notify_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_pull_o   (sda_pull),
    .intr_en_i    (intr_en),
    .sts_clr_i    (sts_clr),
    .notify_sts_o (sts),
    .notify_irq_o (irq),
    .dev_addr_o   (dev),
    .data_lo_o    (lo),
    .data_hi_o    (hi)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit accepts(input bit [6:0] a, input bit rw, input bit pend);
    return (a == HOST) && !rw && !pend;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wt(5);
    scl_m = 1'b1; wt(10);
    sda_m = 1'b0; wt(10);
    scl_m = 1'b0; wt(5);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(5);
    scl_m = 1'b1; wt(10);
    sda_m = 1'b1; wt(10);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wt(5);
    scl_m = 1'b1; wt(10);
    scl_m = 1'b0; wt(5);
  endtask

  task automatic send_byte(input bit [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wt(5);
    scl_m = 1'b1; wt(5);
    ack = (sda_line == 1'b0);
    wt(5);
    scl_m = 1'b0; wt(5);
  endtask

  task automatic check_state(input string req);
    chk(req, "status", sts, e_sts);
    chk("R9", "irq", irq, e_sts & intr_en);
    chk(req, "dev_addr", dev, e_dev);
    chk(req, "data_lo", lo, e_lo);
    chk(req, "data_hi", hi, e_hi);
  endtask

  task automatic frame(input bit [6:0] a, input bit rw, input bit [6:0] d,
                       input bit [7:0] l, input bit [7:0] h,
                       input int nb, input bit with_stop);
    bit [7:0] bytes [4];
    bit ok, ack;
    string tag;
    bytes[0] = {a, rw};
    bytes[1] = {d, 1'b0};
    bytes[2] = l;
    bytes[3] = h;
    ok = accepts(a, rw, e_sts);
    bus_start();
    for (int k = 0; k < nb; k++) begin
      send_byte(bytes[k], ack);
      if (k != 0)                        tag = "R5";
      else if (e_sts)                    tag = "R7";
      else if (ok)                       tag = "R2";
      else                               tag = "R3";
      chk(tag, "ack", ack, ok);
    end
    if (with_stop) begin
      bus_stop();
      wt(10);
      if (ok && nb == 4) begin
        e_sts = 1'b1; e_dev = d; e_lo = l; e_hi = h;
        check_state("R4");
      end else if (!ok) begin
        check_state("R3");
      end else begin
        check_state("R6");
      end
    end
  endtask

  task automatic clear_sts();
    sts_clr = 1'b1; wt(1);
    sts_clr = 1'b0; wt(2);
    e_sts = 1'b0;
    chk("R8", "status after clear", sts, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    bit [31:0] r;
    r = $urandom(32'h5eed);
    wt(4);
    // R1: reset state
    chk("R1", "pull", sda_pull, 1'b0);
    chk("R1", "status", sts, 1'b0);
    chk("R1", "irq", irq, 1'b0);
    chk("R1", "dev_addr", dev, 7'h0);
    chk("R1", "data", {hi, lo}, 16'h0);
    rst_n = 1'b1;
    wt(10);

    // R2/R4/R5: full notify, interrupt disabled
    frame(HOST, 1'b0, 7'h2a, 8'h5c, 8'ha3, 4, 1'b1);
    chk("R9", "irq masked", irq, 1'b0);
    intr_en = 1'b1; wt(2);
    chk("R9", "irq enabled", irq, 1'b1);

    // R7: second notify refused while pending, values held
    frame(HOST, 1'b0, 7'h11, 8'h22, 8'h33, 4, 1'b1);
    chk("R7", "held dev_addr", dev, 7'h2a);

    // R8: clear then accepted again
    clear_sts();
    chk("R9", "irq after clear", irq, 1'b0);
    frame(HOST, 1'b0, 7'h7f, 8'hff, 8'h01, 4, 1'b1);
    chk("R8", "accepted after clear", sts, 1'b1);
    clear_sts();

    // R3: read bit and wrong address
    frame(HOST, 1'b1, 7'h05, 8'h06, 8'h07, 4, 1'b1);
    frame(7'h09, 1'b0, 7'h05, 8'h06, 8'h07, 4, 1'b1);
    chk("R3", "status after wrong address", sts, 1'b0);

    // R6: frame cut short by a stop after three bytes
    frame(HOST, 1'b0, 7'h44, 8'h55, 8'h66, 3, 1'b1);
    chk("R6", "no status after short frame", sts, 1'b0);

    // R10: repeated start after two bytes, then a full frame
    frame(HOST, 1'b0, 7'h33, 8'h00, 8'h00, 2, 1'b0);
    frame(HOST, 1'b0, 7'h19, 8'h9a, 8'hbc, 4, 1'b1);
    chk("R10", "dev_addr after restart", dev, 7'h19);
    chk("R10", "data after restart", {hi, lo}, 16'hbc9a);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      bit [6:0] a;
      bit rw;
      int nb;
      a  = ($urandom % 4 == 0) ? 7'($urandom) : HOST;
      rw = ($urandom % 8 == 0);
      nb = ($urandom % 5 == 0) ? int'(1 + $urandom % 3) : 4;
      intr_en = 1'($urandom);
      wt(2);
      frame(a, rw, 7'($urandom), 8'($urandom), 8'($urandom), nb, 1'b1);
      if ($urandom % 2 == 0) clear_sts();
    end

    done = 1'b1;
    finish_run();
  end

endmodule